// File: doc/BRIEF.md
# Two-wire divider-setting slave

This block is the slave end of a two-wire serial bus: a clock line driven by the master and a shared data line. The data line is open-drain and pulled high by an external resistor. The master loads frequency-divider settings into a small bank of byte registers through this block and reads them back. The block runs on a fast system clock. It passes both bus lines through a synchronizer and detects bus edges, start conditions and stop conditions in the system-clock domain. It drives the data line only by pulling it low through an output enable.

A write transfer has a fixed layout. After a start condition comes the address byte: seven address bits followed by a direction bit. Two dummy bytes follow, which the slave acknowledges and discards. The next three bytes go into latch 0, latch 1 and latch 2, in that order. Any bytes after those are acknowledged and dropped. A read transfer returns two zero bytes first, then the three latches. A one-cycle update strobe marks every stop condition that ends a transfer in which at least one latch was written.

The controller is a single state machine. Its states are:
- IDLE: waiting for a start condition.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging the address.
- RX: shifting in a written byte.
- RX_ACK: acknowledging a written byte.
- TX: shifting out a read byte.
- TX_ACK: watching the master's acknowledge.
- IGNORE: deaf until the next start or stop.

Its transitions are:
- A start condition moves any state to ADDR.
- A stop condition moves any state to IDLE.
- At the eighth falling edge of the bus clock, ADDR goes to ADDR_ACK if the address matches and to IGNORE if it does not.
- On the next falling edge, ADDR_ACK goes to RX when the direction bit is 0 and to TX when it is 1.
- RX goes to RX_ACK after eight bits, and RX_ACK returns to RX on the next falling edge.
- TX goes to TX_ACK after eight bits. TX_ACK returns to TX when the master acknowledges and goes to IGNORE when it does not.

Top module: `twi_divider_slave`

## Requirements
- R1: After reset, all latch bytes read 0x00, sda_oe is low and update_stb is low.
- R2: A stop condition (data rises while the clock is high) ends any transfer and releases the data line within one system cycle. A start condition (data falls while the clock is high) begins address reception.
- R3: When the seven bits received first, most significant bit first, equal SLAVE_ADDR, the slave pulls data low during the acknowledge slot. Otherwise it leaves the slot high and acknowledges nothing until the next start.
- R4: In a write transfer (direction bit 0), the first two bytes after the address are acknowledged and change no latch.
- R5: The third, fourth and fifth bytes after the address are acknowledged and stored in latch 0, latch 1 and latch 2. Latch k sits at latch_q[8k+7:8k].
- R6: Bytes after the fifth are acknowledged and leave every latch unchanged.
- R7: update_stb is high for exactly one cycle after a stop condition that follows a transfer which stored at least one byte. It stays low after any other stop.
- R8: In a read transfer (direction bit 1), the slave sends 0x00, 0x00, latch 0, latch 1 and latch 2, most significant bit first. Every further byte reads 0xFF.
- R9: When the master leaves the acknowledge slot of a read byte high, the slave stops driving until the next start or stop.
- R10: A start condition in the middle of a transfer restarts address reception, and byte counting begins again from the address byte.
- R11: sda_oe is asserted only during an acknowledge slot the slave gives, or during a 0 bit of a byte it sends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the data pad is pulled low |
| latch_q | output | 8*NUM_LATCH | Stored divider bytes, latch k at bits [8k+7:8k] |
| update_stb | output | 1 | One-cycle pulse after a stop that ends a storing write |

## Verification
The bench builds the block with SLAVE_ADDR set to 7'h2C and keeps NUM_DUMMY at 2 and NUM_LATCH at 3. With a bus quarter-period of ten system cycles, the bus runs 40 times slower than the system clock. These values let short transfers reach every byte position: the dummy window, all three latches, and the saturated overflow index where writes are dropped and reads return 0xFF. Mismatched addresses, repeated starts, stops after dummy-only writes, and early master NACKs all fit in a few transfers.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_latch_bank.sv
module twi_latch_bank #(
    parameter int NUM_LATCH = 3,
    parameter int LSEL_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [LSEL_W-1:0]      sel,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output logic [8*NUM_LATCH-1:0] flat_q
);
    logic [7:0] lat [NUM_LATCH];

    for (genvar k = 0; k < NUM_LATCH; k++) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lat[k] <= 8'h00;
            else if (we && (sel == LSEL_W'(k)))
                lat[k] <= wdata;
        end
        assign flat_q[8*k +: 8] = lat[k];
    end

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < NUM_LATCH; k++)
            if (sel == LSEL_W'(k)) rdata = lat[k];
    end
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
    import twi_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int NUM_DUMMY = 2,
    parameter int NUM_LATCH = 3,
    parameter int LSEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [7:0]        rd_data,
    output logic [LSEL_W-1:0] lat_sel,
    output logic              lat_we,
    output logic [7:0]        lat_wdata,
    output logic              sda_oe,
    output logic              update_stb,
    output twi_state_e        state
);
    localparam int TOTAL = NUM_DUMMY + NUM_LATCH;
    localparam int IDX_W = $clog2(TOTAL + 1);
    localparam logic [IDX_W-1:0] DUMMY_C = IDX_W'(NUM_DUMMY);
    localparam logic [IDX_W-1:0] TOTAL_C = IDX_W'(TOTAL);

    twi_state_e state_q, state_d;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [IDX_W-1:0] idx, idx_off;
    logic             wrote, stb_q, in_window;
    logic [7:0]       tx_byte;

    assign idx_off   = idx - DUMMY_C;
    assign lat_sel   = idx_off[LSEL_W-1:0];
    assign in_window = (idx >= DUMMY_C) && (idx < TOTAL_C);
    assign lat_wdata = shreg;
    assign state     = state_q;
    assign update_stb = stb_q;

    always_comb begin
        if (idx < DUMMY_C)  tx_byte = 8'h00;
        else if (in_window) tx_byte = rd_data;
        else                tx_byte = 8'hFF;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_det)
            state_d = ST_IDLE;
        else if (start_det)
            state_d = ST_ADDR;
        else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:
                    if (scl_fall && bitcnt == 4'd8)
                        state_d = (shreg[7:1] == SLAVE_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall) state_d = shreg[0] ? ST_TX : ST_RX;
                ST_RX:
                    if (scl_fall && bitcnt == 4'd8) state_d = ST_RX_ACK;
                ST_RX_ACK:
                    if (scl_fall) state_d = ST_RX;
                ST_TX:
                    if (scl_fall && bitcnt == 4'd7) state_d = ST_TX_ACK;
                ST_TX_ACK:
                    if (scl_rise && sda_s) state_d = ST_IGNORE;
                    else if (scl_fall)     state_d = ST_TX;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            idx    <= '0;
            wrote  <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= stop_det && wrote;
            if (stop_det) begin
                wrote <= 1'b0;
            end else if (start_det) begin
                bitcnt <= '0;
                idx    <= '0;
            end else begin
                if (lat_we) wrote <= 1'b1;
                unique case (state_q)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (scl_fall && bitcnt == 4'd8 && state_q == ST_RX
                            && idx != TOTAL_C)
                            idx <= idx + 1'b1;
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        if (shreg[0]) shreg <= tx_byte;
                    end
                    ST_RX_ACK: if (scl_fall) bitcnt <= '0;
                    ST_TX: if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7 && idx != TOTAL_C) idx <= idx + 1'b1;
                    end
                    ST_TX_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        shreg  <= tx_byte;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        lat_we = (state_q == ST_RX) && scl_fall && (bitcnt == 4'd8)
                 && in_window && !stop_det && !start_det;
        unique case (state_q)
            ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
            ST_TX:                  sda_oe = ~shreg[7];
            default:                sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/twi_divider_slave.sv
module twi_divider_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int NUM_DUMMY   = 2,
    parameter int NUM_LATCH   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    output logic [8*NUM_LATCH-1:0] latch_q,
    output logic                   update_stb
);
    localparam int LSEL_W = (NUM_LATCH > 1) ? $clog2(NUM_LATCH) : 1;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic lat_we;
    logic [LSEL_W-1:0] lat_sel;
    logic [7:0] lat_wdata, rd_data;
    twi_state_e state;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_ctrl #(
        .SLAVE_ADDR(SLAVE_ADDR), .NUM_DUMMY(NUM_DUMMY),
        .NUM_LATCH(NUM_LATCH), .LSEL_W(LSEL_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .lat_sel(lat_sel), .lat_we(lat_we),
        .lat_wdata(lat_wdata), .sda_oe(sda_oe), .update_stb(update_stb),
        .state(state)
    );

    twi_latch_bank #(.NUM_LATCH(NUM_LATCH), .LSEL_W(LSEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(lat_we), .sel(lat_sel),
        .wdata(lat_wdata), .rdata(rd_data), .flat_q(latch_q)
    );
endmodule

// File: rtl/twi_divider_slave_chk.sv
module twi_divider_slave_chk
    import twi_pkg::*;
#(
    parameter int NUM_LATCH = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sda_oe,
    input logic                   update_stb,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   lat_we,
    input logic [8*NUM_LATCH-1:0] latch_q,
    input twi_state_e             state
);
    p_release_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    p_cond_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
    p_ignore_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_we |=> $stable(latch_q));
    p_stb_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |-> $past(stop_det));
    p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |=> !update_stb);
    p_oe_context_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_RX_ACK || state == ST_TX));
endmodule

bind twi_divider_slave twi_divider_slave_chk #(.NUM_LATCH(NUM_LATCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .update_stb(update_stb),
    .start_det(start_det), .stop_det(stop_det), .lat_we(lat_we),
    .latch_q(latch_q), .state(state)
);

// File: tb/sim_twi_divider_slave.sv
module sim_twi_divider_slave;
    localparam logic [6:0] ADDR = 7'h2C;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, update_stb, sda_line;
    logic [23:0] latch_q;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    twi_divider_slave #(.SLAVE_ADDR(ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .latch_q(latch_q), .update_stb(update_stb)
    );

    int n_chk = 0, n_fail = 0, stb_cnt = 0;
    bit done = 0;

    typedef struct { string tag; logic [7:0] val; } item_t;
    item_t  exp_q[$];
    logic [7:0] obs_q[$];

    always @(posedge clk) if (update_stb) stb_cnt++;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // scoreboard monitor
    initial forever begin
        @(posedge clk);
        while (obs_q.size() > 0) begin
            logic [7:0] o;
            item_t e;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) chk("SB-extra", {24'h0, o}, 32'hDEAD);
            else begin
                e = exp_q.pop_front();
                chk(e.tag, {24'h0, o}, {24'h0, e.val});
            end
        end
    end

    task automatic push_exp(input string tag, input logic [7:0] v);
        item_t it;
        it.tag = tag; it.val = v;
        exp_q.push_back(it);
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    // sends a byte, records the ack slot level (0 = ack)
    task automatic wr_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        obs_q.push_back({7'h0, sda_line});
        wq(); m_scl = 1'b0; wq();
    endtask

    task automatic rd_byte(input bit ack);
        logic [7:0] b;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq(); b[i] = sda_line; wq(); m_scl = 1'b0;
        end
        obs_q.push_back(b);
        wq(); m_sda = ack ? 1'b0 : 1'b1; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic drain();
        repeat (4) @(posedge clk);
        #1;
        chk("SB-pending", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int s0;
        repeat (5) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 latches", latch_q, 24'h0);
        chk("R1 oe", sda_oe, 0);
        chk("R1 stb", update_stb, 0);
        rst_n = 1'b1;
        wq(2);

        // R3 R4 R5 R6: full write with extra bytes
        s0 = stb_cnt;
        bus_start();
        push_exp("R3 addr ack", 0);   wr_byte({ADDR, 1'b0});
        push_exp("R4 dummy0 ack", 0); wr_byte(8'hAA);
        chk("R4 dummy no store", latch_q, 24'h0);
        push_exp("R4 dummy1 ack", 0); wr_byte(8'h55);
        chk("R4 dummy no store", latch_q, 24'h0);
        push_exp("R5 d0 ack", 0); wr_byte(8'h12);
        push_exp("R5 d1 ack", 0); wr_byte(8'h34);
        push_exp("R5 d2 ack", 0); wr_byte(8'h56);
        chk("R5 latches", latch_q, 24'h563412);
        push_exp("R6 extra ack", 0); wr_byte(8'h77);
        push_exp("R6 extra ack", 0); wr_byte(8'h88);
        chk("R6 unchanged", latch_q, 24'h563412);
        bus_stop();
        wq();
        chk("R2 released after stop", sda_oe, 0);
        chk("R7 one strobe", stb_cnt - s0, 1);
        drain();

        // R8 read back with overflow byte
        s0 = stb_cnt;
        bus_start();
        push_exp("R3 read addr ack", 0); wr_byte({ADDR, 1'b1});
        push_exp("R8 dummy0", 8'h00); rd_byte(1);
        push_exp("R8 dummy1", 8'h00); rd_byte(1);
        push_exp("R8 lat0", 8'h12); rd_byte(1);
        push_exp("R8 lat1", 8'h34); rd_byte(1);
        push_exp("R8 lat2", 8'h56); rd_byte(1);
        push_exp("R8 beyond", 8'hFF); rd_byte(0);
        bus_stop();
        chk("R7 no strobe after read", stb_cnt - s0, 0);
        drain();

        // R3 wrong address
        s0 = stb_cnt;
        bus_start();
        push_exp("R3 mismatch nack", 1); wr_byte({ADDR ^ 7'h01, 1'b0});
        push_exp("R3 ignored nack", 1); wr_byte(8'h00);
        push_exp("R3 ignored nack", 1); wr_byte(8'h00);
        push_exp("R3 ignored nack", 1); wr_byte(8'hEE);
        bus_stop();
        chk("R3 latches kept", latch_q, 24'h563412);
        chk("R3 no strobe", stb_cnt - s0, 0);
        drain();

        // R10 repeated start mid transfer
        s0 = stb_cnt;
        bus_start();
        push_exp("R10 addr ack", 0); wr_byte({ADDR, 1'b0});
        push_exp("R10 dummy ack", 0); wr_byte(8'h01);
        bus_start();
        push_exp("R10 re-addr ack", 0); wr_byte({ADDR, 1'b0});
        push_exp("R10 dummy ack", 0); wr_byte(8'h02);
        push_exp("R10 dummy ack", 0); wr_byte(8'h03);
        push_exp("R10 d0 ack", 0); wr_byte(8'hC3);
        bus_stop();
        chk("R10 latch0 only", latch_q, 24'h5634C3);
        chk("R7 strobe after one byte", stb_cnt - s0, 1);
        drain();

        // R7 dummies only: no strobe
        s0 = stb_cnt;
        bus_start();
        push_exp("R4 addr ack", 0); wr_byte({ADDR, 1'b0});
        push_exp("R4 dummy ack", 0); wr_byte(8'hF0);
        push_exp("R4 dummy ack", 0); wr_byte(8'h0F);
        bus_stop();
        chk("R7 no strobe dummies only", stb_cnt - s0, 0);
        chk("R4 latches kept", latch_q, 24'h5634C3);
        drain();

        // R9 early master nack: slave releases
        bus_start();
        push_exp("R9 addr ack", 0); wr_byte({ADDR, 1'b1});
        push_exp("R9 dummy", 8'h00); rd_byte(0);
        push_exp("R9 released", 8'hFF); rd_byte(0);
        chk("R11 oe idle after nack", sda_oe, 0);
        bus_stop();
        drain();

        finish_run();
    end
endmodule